// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block holds the pad configuration of one 8-pin GPIO port. Software reaches it over a plain register bus with an address, a write strobe, write data and combinational read data. Each register keeps one bit per pin for one pad property: direction, peripheral (alternate) control, open-drain, digital enable, pull-up, pull-down, three drive strengths and slew-rate limiting. The block drives decoded per-pin control vectors toward the pad ring.

Two groups of registers are mutually exclusive per pin, and the hardware keeps them that way. A pin never has both pulls enabled, and it always has exactly one drive strength. A write that turns a pin's bit on in one member of a group turns that pin's bit off in the other members in the same clock edge. Reads always show the current contents, including bits that were cleared this way. Debug pins, given by a parameter mask, come out of reset with digital function enabled so that they stay usable.

Top module: `gpio_padcfg_bank`

## Requirements
- R1: After reset, direction, alternate, open-drain, pull-up, pull-down, 4 mA, 8 mA and slew registers read 0, the 2 mA register reads all ones, and digital enable reads the parameter `DEN_RST` (default 8'h0C).
- R2: The address map is direction 0, alternate 1, open-drain 2, digital enable 3 and slew 9. A write to any of these replaces the whole register, the value reads back, and it appears on the matching pad vector on the next cycle.
- R3: A write to the pull-up register (address 4) replaces it and clears, for each pin written 1, that pin's pull-down bit. Pins written 0 leave pull-down unchanged, so pull-up AND pull-down is always 0.
- R4: A write to the pull-down register (address 5) replaces it and clears, for each pin written 1, that pin's pull-up bit. Pins written 0 leave pull-up unchanged.
- R5: Drive registers are 2 mA at address 6, 4 mA at 7 and 8 mA at 8. A 1 written for a pin selects that strength and clears the pin in the other two. A 0 written has no effect, so each pin has exactly one strength at all times.
- R6: The effective slew output for a pin is 1 only when its slew bit and its 8 mA bit are both set.
- R7: The open-drain output vector is open-drain AND direction, and the open-drain input vector is open-drain AND NOT direction.
- R8: Reading a register returns bits that were cleared automatically by a write to a sibling register.
- R9: Writes to addresses 10 to 15 change no register, and reads from them return 0.
- R10: With the write strobe low, no register changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW (4) | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | NPIN (8) | Write data |
| rdata | output | NPIN (8) | Read data of the addressed register |
| pad_dir | output | NPIN | 1 = output |
| pad_alt | output | NPIN | 1 = peripheral controls the pin |
| pad_den | output | NPIN | Digital enable |
| pad_od_out | output | NPIN | Open-drain output pins |
| pad_od_in | output | NPIN | Open-drain input pins |
| pad_pu | output | NPIN | Weak pull-up enable |
| pad_pd | output | NPIN | Weak pull-down enable |
| pad_drv2 | output | NPIN | 2 mA drive selected |
| pad_drv4 | output | NPIN | 4 mA drive selected |
| pad_drv8 | output | NPIN | 8 mA drive selected |
| pad_slew | output | NPIN | Effective slew-rate control |

## Verification
A single write can both load its own register and clear bits in a sibling register, and the two updates land on the same clock edge. The bench provokes this by preloading a sibling with a pattern that overlaps the written value. It sweeps all 256 data values for each pull register and for the drive registers, and it also runs a long pseudo-random write stream over every address. After each write it compares every register readback and every pad vector with a bench model that applies the set and clear arithmetic per pin. Because the slew output depends on the 8 mA bit, moving a pin to another drive strength also drops its effective slew in the same cycle, and the bench checks that as well.

// File: rtl/gpio_padcfg_bank.sv
module gpio_padcfg_bank #(
  parameter int NPIN = 8,
  parameter int AW = 4,
  parameter logic [NPIN-1:0] DEN_RST = NPIN'('h0C)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] rdata,
  output logic [NPIN-1:0] pad_dir,
  output logic [NPIN-1:0] pad_alt,
  output logic [NPIN-1:0] pad_den,
  output logic [NPIN-1:0] pad_od_out,
  output logic [NPIN-1:0] pad_od_in,
  output logic [NPIN-1:0] pad_pu,
  output logic [NPIN-1:0] pad_pd,
  output logic [NPIN-1:0] pad_drv2,
  output logic [NPIN-1:0] pad_drv4,
  output logic [NPIN-1:0] pad_drv8,
  output logic [NPIN-1:0] pad_slew
);
  localparam logic [AW-1:0] A_DIR = AW'(0);
  localparam logic [AW-1:0] A_ALT = AW'(1);
  localparam logic [AW-1:0] A_ODE = AW'(2);
  localparam logic [AW-1:0] A_DEN = AW'(3);
  localparam logic [AW-1:0] A_PUP = AW'(4);
  localparam logic [AW-1:0] A_PDN = AW'(5);
  localparam logic [AW-1:0] A_D2  = AW'(6);
  localparam logic [AW-1:0] A_D4  = AW'(7);
  localparam logic [AW-1:0] A_D8  = AW'(8);
  localparam logic [AW-1:0] A_SLW = AW'(9);

  logic [NPIN-1:0] dir_q, alt_q, ode_q, den_q, pup_q, pdn_q, d2_q, d4_q, d8_q, slw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      alt_q <= '0;
      ode_q <= '0;
      den_q <= DEN_RST;
      pup_q <= '0;
      pdn_q <= '0;
      d2_q  <= '1;
      d4_q  <= '0;
      d8_q  <= '0;
      slw_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DIR: dir_q <= wdata;
        A_ALT: alt_q <= wdata;
        A_ODE: ode_q <= wdata;
        A_DEN: den_q <= wdata;
        A_SLW: slw_q <= wdata;
        A_PUP: begin
          pup_q <= wdata;
          pdn_q <= pdn_q & ~wdata;
        end
        A_PDN: begin
          pdn_q <= wdata;
          pup_q <= pup_q & ~wdata;
        end
        A_D2: begin
          d2_q <= d2_q | wdata;
          d4_q <= d4_q & ~wdata;
          d8_q <= d8_q & ~wdata;
        end
        A_D4: begin
          d4_q <= d4_q | wdata;
          d2_q <= d2_q & ~wdata;
          d8_q <= d8_q & ~wdata;
        end
        A_D8: begin
          d8_q <= d8_q | wdata;
          d2_q <= d2_q & ~wdata;
          d4_q <= d4_q & ~wdata;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_DIR:   rdata = dir_q;
      A_ALT:   rdata = alt_q;
      A_ODE:   rdata = ode_q;
      A_DEN:   rdata = den_q;
      A_PUP:   rdata = pup_q;
      A_PDN:   rdata = pdn_q;
      A_D2:    rdata = d2_q;
      A_D4:    rdata = d4_q;
      A_D8:    rdata = d8_q;
      A_SLW:   rdata = slw_q;
      default: rdata = '0;
    endcase
  end

  assign pad_dir    = dir_q;
  assign pad_alt    = alt_q;
  assign pad_den    = den_q;
  assign pad_od_out = ode_q & dir_q;
  assign pad_od_in  = ode_q & ~dir_q;
  assign pad_pu     = pup_q;
  assign pad_pd     = pdn_q;
  assign pad_drv2   = d2_q;
  assign pad_drv4   = d4_q;
  assign pad_drv8   = d8_q;
  assign pad_slew   = slw_q & d8_q;

  AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n) (pad_pu & pad_pd) == '0); // R3
  AST_PDN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PDN) |=> (pad_pd == $past(wdata))); // R4
  AST_SLEW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_D2) |=> ((pad_slew & $past(wdata)) == '0)); // R6
  AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr > A_SLW) |=> $stable({dir_q, alt_q, ode_q, den_q, pup_q, pdn_q, d2_q, d4_q, d8_q, slw_q})); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({dir_q, alt_q, ode_q, den_q, pup_q, pdn_q, d2_q, d4_q, d8_q, slw_q})); // R10

  for (genvar i = 0; i < NPIN; i++) begin : g_drv_chk
    AST_DRV_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({pad_drv2[i], pad_drv4[i], pad_drv8[i]}) == 1); // R5
  end
endmodule

// File: tb/tb_gpio_padcfg_bank.sv
`timescale 1ns/1ps
module tb_gpio_padcfg_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, pad_dir, pad_alt, pad_den, pad_od_out, pad_od_in;
  logic [7:0] pad_pu, pad_pd, pad_drv2, pad_drv4, pad_drv8, pad_slew;

  int nchk = 0;
  int nfail = 0;
  logic [7:0] m [0:9];
  logic [15:0] lf = 16'hACE1;

  always #4 clk = ~clk;

  gpio_padcfg_bank #(.NPIN(8), .AW(4), .DEN_RST(8'h0C)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .pad_dir(pad_dir), .pad_alt(pad_alt), .pad_den(pad_den), .pad_od_out(pad_od_out),
    .pad_od_in(pad_od_in), .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_drv2(pad_drv2),
    .pad_drv4(pad_drv4), .pad_drv8(pad_drv8), .pad_slew(pad_slew));

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic string tag_of(input int a);
    if (a == 4) return "R3";
    if (a == 5) return "R4";
    if (a >= 6 && a <= 8) return "R5";
    if (a > 9) return "R9";
    return "R2";
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 10; i++) m[i] = 8'h00;
    m[3] = 8'h0C;
    m[6] = 8'hFF;
  endtask

  task automatic model_write(input int a, input logic [7:0] d);
    case (a)
      0, 1, 2, 3, 9: m[a] = d;
      4: begin m[4] = d; m[5] = m[5] & ~d; end
      5: begin m[5] = d; m[4] = m[4] & ~d; end
      6, 7, 8: begin
        for (int k = 6; k <= 8; k++) m[k] = (k == a) ? (m[k] | d) : (m[k] & ~d);
      end
      default: ;
    endcase
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = 4'(a);
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic full_check(input string ovr);
    for (int a = 0; a < 16; a++) begin
      addr = 4'(a);
      #1;
      chk(ovr != "" ? ovr : tag_of(a), rdata, (a <= 9) ? m[a] : 8'h00);
    end
    chk(ovr != "" ? ovr : "R2", pad_dir, m[0]);
    chk(ovr != "" ? ovr : "R2", pad_alt, m[1]);
    chk(ovr != "" ? ovr : "R2", pad_den, m[3]);
    chk(ovr != "" ? ovr : "R3", pad_pu, m[4]);
    chk(ovr != "" ? ovr : "R4", pad_pd, m[5]);
    chk(ovr != "" ? ovr : "R5", pad_drv2, m[6]);
    chk(ovr != "" ? ovr : "R5", pad_drv4, m[7]);
    chk(ovr != "" ? ovr : "R5", pad_drv8, m[8]);
    chk(ovr != "" ? ovr : "R6", pad_slew, m[9] & m[8]);
    chk(ovr != "" ? ovr : "R7", pad_od_out, m[2] & m[0]);
    chk(ovr != "" ? ovr : "R7", pad_od_in, m[2] & ~m[0]);
  endtask

  initial begin
    #(8 * 200000);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    full_check("R1");

    for (int d = 0; d < 256; d++) begin
      wr(5, 8'(d) ^ 8'hA5);
      wr(4, 8'(d));
      full_check("");
    end
    for (int d = 0; d < 256; d++) begin
      wr(4, ~8'(d));
      wr(5, 8'(d));
      full_check("");
    end
    wr(9, 8'hFF);
    for (int d = 0; d < 256; d++) begin
      wr(6 + (d % 3), 8'(d));
      full_check("");
    end

    wr(5, 8'hFF);
    wr(4, 8'h0F);
    addr = 4'd5; #1;
    chk("R8", rdata, 8'hF0);
    wr(6, 8'hFF);
    wr(8, 8'h33);
    addr = 4'd6; #1;
    chk("R8", rdata, 8'hCC);

    @(negedge clk);
    addr = 4'd0; wdata = 8'h5A; wr_en = 1'b0;
    @(negedge clk);
    addr = 4'd8; wdata = 8'hFF;
    @(negedge clk);
    full_check("R10");

    for (int n = 0; n < 2000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      wr(int'(lf[3:0]), lf[15:8]);
      if (n % 4 == 0) full_check("");
    end
    full_check("");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule